// File: doc/BRIEF.md
# Division-free similarity threshold comparator

This block decides whether a pair of binary fingerprints is more or less similar than a programmed threshold. It never divides. It receives three population counts: the weight of fingerprint A, the weight of fingerprint B, and the weight of their bitwise AND. The intersection weight selects an entry in a small on-chip table. That entry holds a precomputed limit for that intersection weight. The block adds the two individual weights and raises a one-bit verdict when the sum is strictly greater than the limit read from the table. A valid flag accompanies the verdict.

Software fills the table through a simple memory-style write port, which has a write enable, an address and a data word. The table has one entry for each possible intersection weight, from 0 to `VEC_W`. Each entry is wide enough to hold any weight sum, from 0 to 2·`VEC_W`. A lookup takes one clock cycle. The weight sum and the valid flag are registered alongside the synchronous table read, so the verdict for a request presented in one cycle appears in the next cycle.

Top module: `sim_threshold_cmp`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid` and `out_over` are 0.
- R2: `out_valid` in cycle k+1 equals `in_valid` in cycle k.
- R3: When `out_valid` is 1, `out_over` is 1 exactly when `cnt_a + cnt_b` from the previous cycle, computed without truncation, is greater than the table entry addressed by that cycle's `cnt_c`.
- R4: The comparison is strict. A weight sum equal to the table entry gives `out_over` = 0.
- R5: When `cfg_we` is 1 and `cfg_addr` ≤ `VEC_W`, `cfg_wdata` is stored at `cfg_addr`. A lookup issued in any later cycle uses the new value.
- R6: When a write and a lookup target the same entry in the same cycle, the lookup uses the entry's previous contents.
- R7: While `cfg_we` is 0, `cfg_addr` and `cfg_wdata` have no effect on the table.
- R8: A write with `cfg_addr` > `VEC_W` changes no table entry.
- R9: `out_over` is 0 whenever `out_valid` is 0.
- R10: Reset does not clear or alter the table contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Lookup request present this cycle |
| cnt_a | input | $clog2(VEC_W+1) | Weight of fingerprint A |
| cnt_b | input | $clog2(VEC_W+1) | Weight of fingerprint B |
| cnt_c | input | $clog2(VEC_W+1) | Weight of A AND B; selects the table entry |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | $clog2(VEC_W+1) | Table write address |
| cfg_wdata | input | $clog2(2*VEC_W+1) | Table write data (limit value) |
| out_valid | output | 1 | Verdict valid |
| out_over | output | 1 | 1 when the weight sum exceeds the limit |

## Verification
The bench builds the block with the default `VEC_W` = 16. This gives a 5-bit intersection address over a 17-entry table, so some address codes (17 to 31) map to no entry. It also gives a 6-bit limit word, which can hold the maximum weight sum of 32. With these widths the bench can reach out-of-range writes, writes whose low address bits would alias a real entry, and the full-sum corner. The bench also sweeps every entry at its equality boundary and one above it. It then runs random lookups with writes interleaved in the same cycle.

// File: rtl/sim_thr_pkg.sv
package sim_thr_pkg;

    // Bits needed to hold a weight from 0 to vec_w.
    function automatic int cnt_bits(input int vec_w);
        return $clog2(vec_w + 1);
    endfunction

    // Bits needed to hold a weight sum from 0 to 2*vec_w.
    function automatic int sum_bits(input int vec_w);
        return $clog2(2 * vec_w + 1);
    endfunction

    typedef enum logic {
        VERDICT_BELOW = 1'b0,
        VERDICT_ABOVE = 1'b1
    } verdict_e;

endpackage

// File: rtl/thr_table_ram.sv
module thr_table_ram #(
    parameter int ENTRIES = 17,
    parameter int AW      = 5,
    parameter int DW      = 6
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int SPAN = 1 << AW;

    logic [DW-1:0] mem [ENTRIES];
    logic          wr_hit;
    logic          rd_hit;

    // Only addresses that name a real entry take part.
    assign wr_hit = (int'(wr_addr) < ENTRIES);
    assign rd_hit = (int'(rd_addr) < ENTRIES);

    generate
        if (SPAN < ENTRIES) begin : g_bad_cfg
            initial $error("thr_table_ram: address too narrow for entry count");
        end
    endgenerate

    // Read-before-write: the registered read sees the old contents.
    always_ff @(posedge clk) begin
        if (wr_en && wr_hit) begin
            mem[wr_addr] <= wr_data;
        end
        if (rd_hit) begin
            rd_data <= mem[rd_addr];
        end else begin
            rd_data <= '1;
        end
    end

endmodule

// File: rtl/thr_align_stage.sv
module thr_align_stage #(
    parameter int CW = 5,
    parameter int SW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [CW-1:0] cnt_a,
    input  logic [CW-1:0] cnt_b,
    output logic          q_valid,
    output logic [SW-1:0] q_sum
);
    typedef struct packed {
        logic          vld;
        logic [SW-1:0] sum;
    } stage_t;

    stage_t nxt, cur;

    always_comb begin
        nxt.vld = in_valid;
        nxt.sum = SW'(cnt_a) + SW'(cnt_b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign q_valid = cur.vld;
    assign q_sum   = cur.sum;

endmodule

// File: rtl/thr_decide.sv
module thr_decide
    import sim_thr_pkg::*;
#(
    parameter int SW = 6
) (
    input  logic          vld,
    input  logic [SW-1:0] sum,
    input  logic [SW-1:0] limit,
    output verdict_e      verdict
);
    always_comb begin
        if (vld && (sum > limit)) begin
            verdict = VERDICT_ABOVE;
        end else begin
            verdict = VERDICT_BELOW;
        end
    end

endmodule

// File: rtl/sim_threshold_cmp.sv
module sim_threshold_cmp
    import sim_thr_pkg::*;
#(
    parameter int VEC_W = 16,
    localparam int CW  = cnt_bits(VEC_W),
    localparam int SW  = sum_bits(VEC_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [CW-1:0] cnt_a,
    input  logic [CW-1:0] cnt_b,
    input  logic [CW-1:0] cnt_c,
    input  logic          cfg_we,
    input  logic [CW-1:0] cfg_addr,
    input  logic [SW-1:0] cfg_wdata,
    output logic          out_valid,
    output logic          out_over
);
    localparam int ENTRIES = VEC_W + 1;

    logic          st_valid;
    logic [SW-1:0] st_sum;
    logic [SW-1:0] limit;
    verdict_e      verdict;

    thr_table_ram #(
        .ENTRIES (ENTRIES),
        .AW      (CW),
        .DW      (SW)
    ) u_table (
        .clk     (clk),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .rd_addr (cnt_c),
        .rd_data (limit)
    );

    thr_align_stage #(
        .CW (CW),
        .SW (SW)
    ) u_align (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .cnt_a    (cnt_a),
        .cnt_b    (cnt_b),
        .q_valid  (st_valid),
        .q_sum    (st_sum)
    );

    thr_decide #(
        .SW (SW)
    ) u_decide (
        .vld     (st_valid),
        .sum     (st_sum),
        .limit   (limit),
        .verdict (verdict)
    );

    assign out_valid = st_valid;
    assign out_over  = (verdict == VERDICT_ABOVE);

endmodule

// File: rtl/sim_threshold_cmp_chk.sv
module sim_threshold_cmp_chk #(
    parameter int VEC_W = 16,
    localparam int CW  = sim_thr_pkg::cnt_bits(VEC_W),
    localparam int SW  = sim_thr_pkg::sum_bits(VEC_W)
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [CW-1:0] cnt_a,
    input logic [CW-1:0] cnt_b,
    input logic [CW-1:0] cnt_c,
    input logic          cfg_we,
    input logic [CW-1:0] cfg_addr,
    input logic [SW-1:0] cfg_wdata,
    input logic          out_valid,
    input logic          out_over
);
    logic [SW-1:0] sum_now;
    assign sum_now = SW'(cnt_a) + SW'(cnt_b);

    // R2: a request shows up as a valid verdict one cycle later
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2: no request, no verdict
    p_valid_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9: verdict stays low without valid
    p_over_gated_r9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_over);

    // R3: a zero sum can never exceed any limit
    p_zero_sum_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sum_now == '0) |=> !out_over);

    // R5: a lookup right after a write to the same entry uses the written limit
    p_write_used_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_we) && (int'($past(cfg_addr)) <= VEC_W) &&
         in_valid && (cnt_c == $past(cfg_addr)))
        |=> (out_over == ($past(sum_now) > $past(cfg_wdata, 2))));

endmodule

bind sim_threshold_cmp sim_threshold_cmp_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .cnt_a     (cnt_a),
    .cnt_b     (cnt_b),
    .cnt_c     (cnt_c),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .out_valid (out_valid),
    .out_over  (out_over)
);

// File: tb/sim_threshold_cmp_test.sv
`timescale 1ns/1ps
module sim_threshold_cmp_test;
    localparam int VEC_W = 16;
    localparam int CW    = $clog2(VEC_W + 1);
    localparam int SW    = $clog2(2 * VEC_W + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [CW-1:0] cnt_a = '0;
    logic [CW-1:0] cnt_b = '0;
    logic [CW-1:0] cnt_c = '0;
    logic          cfg_we = 1'b0;
    logic [CW-1:0] cfg_addr = '0;
    logic [SW-1:0] cfg_wdata = '0;
    logic          out_valid;
    logic          out_over;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int model [VEC_W+1];

    always #2.5 clk = ~clk;

    sim_threshold_cmp #(.VEC_W(VEC_W)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .cnt_a     (cnt_a),
        .cnt_b     (cnt_b),
        .cnt_c     (cnt_c),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .out_valid (out_valid),
        .out_over  (out_over)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit expect_over(input int a, input int b, input int c);
        return (a + b) > model[c];
    endfunction

    // Called at a falling edge: drives one cycle, checks the verdict at the next falling edge.
    task automatic step(input bit we, input int wa, input int wd,
                        input bit v, input int a, input int b, input int c,
                        input string req);
        bit eo;
        cfg_we    = we;
        cfg_addr  = CW'(wa);
        cfg_wdata = SW'(wd);
        in_valid  = v;
        cnt_a     = CW'(a);
        cnt_b     = CW'(b);
        cnt_c     = CW'(c);
        eo = v && expect_over(a, b, c);
        @(negedge clk);
        if (we && wa <= VEC_W) model[wa] = wd;
        check(out_valid == v, {req, " valid"}, int'(out_valid), int'(v));
        check(out_over == eo, {req, " over"}, int'(out_over), int'(eo));
        cfg_we   = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd7151));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        check(out_over == 1'b0, "R1 over in reset", int'(out_over), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);

        // R5: load the whole table
        for (int i = 0; i <= VEC_W; i++) begin
            step(1'b1, i, (i * 5 + 3) % 33, 1'b0, 0, 0, 0, "R5 load");
        end

        // R4: equality is not over (entry 2 holds 13)
        step(1'b0, 0, 0, 1'b1, 7, 6, 2, "R4 equal sum");
        // R3: one above is over
        step(1'b0, 0, 0, 1'b1, 7, 7, 2, "R3 sum above");
        // R3: full sum 32 against entry 16 (17)
        step(1'b0, 0, 0, 1'b1, 16, 16, 16, "R3 full sum");
        // R9: no request yields no verdict even when the sum would be over
        step(1'b0, 0, 0, 1'b0, 16, 16, 0, "R9 idle");
        // R2: back-to-back requests
        step(1'b0, 0, 0, 1'b1, 0, 0, 0, "R2 first");
        step(1'b0, 0, 0, 1'b1, 16, 0, 0, "R2 second");

        // R6: write entry 3 (18 -> 0) and look it up in the same cycle: old value
        step(1'b1, 3, 0, 1'b1, 5, 5, 3, "R6 same cycle");
        // R5: next lookup sees new value
        step(1'b0, 0, 0, 1'b1, 5, 5, 3, "R5 new value");

        // R7: address and data without enable change nothing (entry 4 holds 23)
        cfg_addr = CW'(4);
        cfg_wdata = '0;
        @(negedge clk);
        step(1'b0, 4, 0, 1'b1, 5, 5, 4, "R7 no enable");

        // R8: out-of-range write whose low bits would hit entry 4
        step(1'b1, 20, 0, 1'b0, 0, 0, 0, "R8 high write");
        step(1'b1, 31, 0, 1'b0, 0, 0, 0, "R8 top write");
        step(1'b0, 0, 0, 1'b1, 5, 5, 4, "R8 entry 4 intact");
        for (int c = 0; c <= VEC_W; c++) begin
            int s = model[c];
            int a = (s > VEC_W) ? VEC_W : s;
            step(1'b0, 0, 0, 1'b1, a, s - a, c, "R8 R4 boundary sweep");
            if (s < 2 * VEC_W) begin
                s = s + 1;
                a = (s > VEC_W) ? VEC_W : s;
                step(1'b0, 0, 0, 1'b1, a, s - a, c, "R8 R3 above sweep");
            end
        end

        // R10: reset keeps the table
        rst = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in second reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        step(1'b0, 0, 0, 1'b1, 5, 5, 3, "R10 entry 3 kept");
        step(1'b0, 0, 0, 1'b1, 12, 12, 4, "R10 entry 4 kept");

        // Random mix of lookups and writes (R3, R5, R6)
        for (int k = 0; k < 400; k++) begin
            bit we = ($urandom % 4) == 0;
            int wa = $urandom % 20;
            int wd = $urandom % (2 * VEC_W + 1);
            bit v  = ($urandom % 5) != 0;
            int c  = (($urandom % 3) == 0) ? wa % (VEC_W + 1) : $urandom % (VEC_W + 1);
            step(we, wa, wd, v, $urandom % (VEC_W + 1), $urandom % (VEC_W + 1), c,
                 "R3 R5 R6 random");
        end

        finish_run();
    end

endmodule